// File: doc/BRIEF.md
# Stereo Peak Level Meter with Bar-Graph Encoding

The block watches two channels of signed audio samples and keeps, per channel, the largest magnitude seen since the last meter update. A falling edge on the asynchronous update pin moves each tracked peak into a held register and restarts tracking from zero. Each held peak is turned into an 8-bit level code, and the overflow line is time-shared between the two channels by the word clock.

Two code formats are available, and one is chosen while reset is asserted. The fine format reports attenuation below full scale in 1 dB steps down to -60 dB. It has an idle flag for very quiet channels, and it reports over-range up to +3 dB. The bar-graph format reports a thermometer code with coarse segments, which suits driving a row of indicator lamps directly.

Full scale is a magnitude of 2^19 on a 22-bit two's-complement sample. This leaves headroom to measure peaks above full scale. dB boundaries are resolved by comparing the held magnitude against a constant threshold per boundary. Threshold k below full scale is floor(2^19 * 10^(-k/20)), and threshold k above it is floor(2^19 * 10^(k/20)).

Top module: `peak_level_meter`

## Requirements
- R1: Each channel's tracker holds the largest magnitude of the valid samples seen since the last update edge. On an update edge the tracker value moves to the held register and the tracker restarts.
- R2: The magnitude is the absolute value of the sample. The most negative input (-2^21) saturates to 2^21-1.
- R3: In fine mode, with held magnitude at or below 2^19, bit 7 is 0. Bits 5..0 give the count of downward thresholds k = 1..60 that the magnitude lies strictly below. For example, 0 means within 1 dB of full scale and 14 means between -14 and -15 dB.
- R4: In fine mode, bit 6 (idle) is 1 exactly when the magnitude is below the -60 dB threshold. In that case bits 5..0 read 60, so a silent channel reads 0x7C.
- R5: In fine mode, with held magnitude strictly above 2^19, bits 7..6 read 10. Bits 5..0 give the count of upward thresholds (+1, +2, +3 dB) that the magnitude reaches, at most 3. A magnitude of exactly 2^19 is not over-range.
- R6: In bar mode the code is as follows, where a range includes its upper bound, e.g. "-3 to 0 dB" means -3 dB < level ≤ 0 dB:
  - 0xFF when over-range.
  - 0x7F for -3 to 0 dB.
  - 0x3F for -6 to -3 dB.
  - 0x1F for -10 to -6 dB.
  - 0x0F for -20 to -10 dB.
  - 0x07 for -30 to -20 dB.
  - 0x03 for -40 to -30 dB.
  - 0x01 for -60 to -40 dB.
  - 0x00 below -60 dB.
- R7: The format select input is captured only while reset is asserted; 0 selects fine mode and 1 selects bar mode. Changing it afterwards has no effect.
- R8: The overflow output shows the left channel's held over-range flag while the word clock is 0, and the right channel's flag while it is 1. A held over-range flag is set when the held magnitude is above 2^19.
- R9: The update pin is synchronized inside the block. Only a high-to-low transition acts, and the held registers change on the third rising clock edge after the pin goes low. A rising transition, or samples without an edge, leave the codes unchanged.
- R10: A valid sample arriving in the cycle the update edge takes effect is not included in the value moved to the held register. It becomes the first value of the restarted tracker.
- R11: After reset, both held magnitudes are zero. Both codes show the silent level, 0x7C in fine mode and 0x00 in bar mode, and the overflow output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_l_i | input | 22 | Left sample, two's complement |
| smp_l_vld_i | input | 1 | Left sample valid strobe |
| smp_r_i | input | 22 | Right sample, two's complement |
| smp_r_vld_i | input | 1 | Right sample valid strobe |
| pk_upd_n_i | input | 1 | Asynchronous meter update, acts on falling edge |
| bar_sel_i | input | 1 | Code format select, sampled during reset (1 = bar graph) |
| word_lr_i | input | 1 | Word clock, 0 = left phase, 1 = right phase |
| code_l_o | output | 8 | Left level code |
| code_r_o | output | 8 | Right level code |
| ovfl_o | output | 1 | Time-shared over-range flag |

## Verification
On every cycle, the embedded properties check the following:
- The tracker never shrinks between update edges, and the held value is stable between update edges.
- An update edge moves exactly the tracker value and cannot repeat on consecutive cycles.
- The fine-format fields stay within their ranges and never set over-range and idle together.
- Bar codes are always thermometer-shaped.
- The overflow line agrees with the selected channel's code, and the captured format never changes outside reset.

Only the bench scenarios can show the rest. That covers the actual dB value chosen for a given magnitude, including the exact full-scale boundary and the saturated most-negative input. It also covers the three-cycle latency of the update edge and the fate of a sample coinciding with that edge.

// File: rtl/pkm_pkg.sv
// Shared constants and constant functions for the peak level meter.
// Assumes full scale is a power of two no larger than 2^19 so that the
// fixed-point threshold arithmetic stays inside 64 bits.
package pkm_pkg;

    localparam int CODE_W     = 8;   // level code width, fixed by the code formats
    localparam int ATT_STEPS  = 60;  // number of 1 dB steps below full scale
    localparam int OVR_STEPS  = 3;   // number of 1 dB steps above full scale
    localparam int BAR_SEGS   = 7;   // segments of the thermometer below overflow
    localparam int ATT_W      = $clog2(ATT_STEPS + 1);
    localparam int OVR_W      = $clog2(OVR_STEPS + 1);
    localparam int SEG_W      = $clog2(BAR_SEGS + 1);
    localparam int FRAC_SH    = 12;  // guard bits of the threshold recursion

    // 10^(-1/20) and 10^(1/20) scaled by 2^30
    localparam longint STEP_DN = 64'd956973408;
    localparam longint STEP_UP = 64'd1204758142;

    // Magnitude threshold k dB below full scale (floor)
    function automatic longint thr_dn(input int k, input int fs_log2);
        longint v;
        v = longint'(1) << (fs_log2 + FRAC_SH);
        for (int i = 0; i < k; i++) begin
            v = (v * STEP_DN) >>> 30;
        end
        return v >>> FRAC_SH;
    endfunction

    // Magnitude threshold k dB above full scale (floor)
    function automatic longint thr_up(input int k, input int fs_log2);
        longint v;
        v = longint'(1) << (fs_log2 + FRAC_SH);
        for (int i = 0; i < k; i++) begin
            v = (v * STEP_UP) >>> 30;
        end
        return v >>> FRAC_SH;
    endfunction

    // Attenuation (dB) at which bar segment i switches off, strongest first
    function automatic int bar_bp(input int i);
        case (i)
            0:       return 3;
            1:       return 6;
            2:       return 10;
            3:       return 20;
            4:       return 30;
            5:       return 40;
            default: return 60;
        endcase
    endfunction

endpackage

// File: rtl/pkm_upd_sync.sv
// Brings the asynchronous update pin into the clock domain and produces a
// one-cycle pulse on its falling edge. Assumes the pin idles high; the
// synchronizer resets to high so reset release never fakes an edge.
module pkm_upd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_n_i,
    output logic upd_fall_o
);

    logic [2:0] sync_q;

    // Three-stage shift: two for metastability, one for edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 3'b111;
        end else begin
            sync_q <= {sync_q[1:0], upd_n_i};
        end
    end

    // Falling edge: old value high, synchronized value low
    assign upd_fall_o = sync_q[2] & ~sync_q[1];

    p_fall_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fall_o |=> !upd_fall_o);

    p_fall_from_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fall_o |-> !$past(upd_n_i, 2));

endmodule

// File: rtl/pkm_peak_track.sv
// One channel's peak tracker: absolute value with saturation, running
// maximum since the last update, and the held register read by the encoder.
// Assumes one valid sample per strobe; the update pulse is one cycle wide.
module pkm_peak_track #(
    parameter int SMP_W = 22,
    localparam int MAG_W = SMP_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             vld_i,
    input  logic             upd_fall_i,
    output logic [MAG_W-1:0] held_o
);

    logic [SMP_W-1:0] neg_w;
    logic [MAG_W-1:0] mag_w;
    logic [MAG_W-1:0] act_q;
    logic [MAG_W-1:0] held_q;

    // Absolute value; the most negative code saturates to all ones
    always_comb begin
        neg_w = ~smp_i + SMP_W'(1);
        if (!smp_i[SMP_W-1]) begin
            mag_w = smp_i[MAG_W-1:0];
        end else if (smp_i[MAG_W-1:0] == '0) begin
            mag_w = '1;
        end else begin
            mag_w = neg_w[MAG_W-1:0];
        end
    end

    // Running maximum and hand-over to the held register on update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            held_q <= '0;
        end else if (upd_fall_i) begin
            held_q <= act_q;
            act_q  <= vld_i ? mag_w : '0;
        end else if (vld_i && (mag_w > act_q)) begin
            act_q  <= mag_w;
        end
    end

    assign held_o = held_q;

    p_act_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_fall_i |=> act_q >= $past(act_q));

    p_hold_takes_act_r1: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fall_i |=> held_q == $past(act_q));

    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_fall_i |=> $stable(held_q));

endmodule

// File: rtl/pkm_level_enc.sv
// Turns a held magnitude into an 8-bit level code, fine dB or thermometer.
// Uses a parallel bank of constant comparators, one per dB boundary, so the
// code is valid in the same cycle as the held magnitude. Assumes the
// thresholds are monotonic, which the constant recursion guarantees.
module pkm_level_enc #(
    parameter int MAG_W   = 21,
    parameter int FS_LOG2 = 19
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [MAG_W-1:0]          mag_i,
    input  logic                      bar_mode_i,
    output logic [pkm_pkg::CODE_W-1:0] code_o,
    output logic                      over_o
);
    import pkm_pkg::*;

    localparam logic [63:0] FS_MAG = 64'(1) << FS_LOG2;

    logic [63:0]            mag64;
    logic [ATT_STEPS-1:0]   below_v;
    logic [OVR_STEPS-1:0]   above_v;
    logic [ATT_W-1:0]       att_cnt;
    logic [OVR_W-1:0]       ovr_cnt;
    logic [SEG_W-1:0]       seg_n;
    logic [CODE_W-1:0]      fine_code;
    logic [CODE_W-1:0]      bar_code;
    logic                   idle;

    assign mag64  = 64'(mag_i);
    assign over_o = mag64 > FS_MAG;

    // Comparators below full scale: bit k-1 set when under the -k dB threshold
    for (genvar k = 1; k <= ATT_STEPS; k++) begin : g_dn
        localparam logic [63:0] THR = 64'(thr_dn(k, FS_LOG2));
        assign below_v[k-1] = mag64 < THR;
    end

    // Comparators above full scale: bit k-1 set when at or over +k dB
    for (genvar k = 1; k <= OVR_STEPS; k++) begin : g_up
        localparam logic [63:0] THR = 64'(thr_up(k, FS_LOG2));
        assign above_v[k-1] = mag64 >= THR;
    end

    // Step counts from the thermometer-shaped comparator vectors
    always_comb begin
        att_cnt = ATT_W'($countones(below_v));
        ovr_cnt = OVR_W'($countones(above_v));
        idle    = below_v[ATT_STEPS-1];
    end

    // Number of lit bar segments from the attenuation count
    always_comb begin
        seg_n = '0;
        for (int i = 0; i < BAR_SEGS; i++) begin
            if (int'(att_cnt) < bar_bp(i)) begin
                seg_n = seg_n + SEG_W'(1);
            end
        end
    end

    // Assemble both code formats and select the active one
    always_comb begin
        if (over_o) begin
            fine_code = {2'b10, 6'(ovr_cnt)};
            bar_code  = '1;
        end else begin
            fine_code = {1'b0, idle, 6'(att_cnt)};
            bar_code  = CODE_W'((9'd1 << seg_n) - 9'd1);
        end
        code_o = bar_mode_i ? bar_code : fine_code;
    end

    p_fine_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bar_mode_i |-> !(code_o[7] && code_o[6]));

    p_fine_over_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bar_mode_i && code_o[7]) |-> code_o[5:0] <= 6'd3);

    p_fine_att_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bar_mode_i && !code_o[7]) |-> code_o[5:0] <= 6'd60);

    p_idle_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bar_mode_i && code_o[6]) |-> code_o[5:0] == 6'd60);

    p_bar_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bar_mode_i |-> ((code_o & (code_o + 8'd1)) == 8'd0));

endmodule

// File: rtl/peak_level_meter.sv
// Stereo peak level meter. Two trackers share one synchronized update pulse;
// each feeds its own encoder. The code format is captured during reset and
// the overflow line is multiplexed by the word clock.
// Assumes the word clock and sample strobes are already in the clk domain.
module peak_level_meter #(
    parameter int SMP_W   = 22,
    parameter int FS_LOG2 = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp_l_i,
    input  logic             smp_l_vld_i,
    input  logic [SMP_W-1:0] smp_r_i,
    input  logic             smp_r_vld_i,
    input  logic             pk_upd_n_i,
    input  logic             bar_sel_i,
    input  logic             word_lr_i,
    output logic [7:0]       code_l_o,
    output logic [7:0]       code_r_o,
    output logic             ovfl_o
);
    localparam int MAG_W = SMP_W - 1;
    localparam int N_CH  = 2;

    logic             upd_fall;
    logic             bar_mode_q;
    logic [SMP_W-1:0] smp_a  [N_CH];
    logic             vld_a  [N_CH];
    logic [MAG_W-1:0] held_a [N_CH];
    logic [7:0]       code_a [N_CH];
    logic             over_a [N_CH];

    // Format select is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_mode_q <= bar_sel_i;
        end
    end

    pkm_upd_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_n_i    (pk_upd_n_i),
        .upd_fall_o (upd_fall)
    );

    assign smp_a[0] = smp_l_i;
    assign smp_a[1] = smp_r_i;
    assign vld_a[0] = smp_l_vld_i;
    assign vld_a[1] = smp_r_vld_i;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        pkm_peak_track #(.SMP_W(SMP_W)) u_track (
            .clk        (clk),
            .rst_n      (rst_n),
            .smp_i      (smp_a[ch]),
            .vld_i      (vld_a[ch]),
            .upd_fall_i (upd_fall),
            .held_o     (held_a[ch])
        );
        pkm_level_enc #(.MAG_W(MAG_W), .FS_LOG2(FS_LOG2)) u_enc (
            .clk        (clk),
            .rst_n      (rst_n),
            .mag_i      (held_a[ch]),
            .bar_mode_i (bar_mode_q),
            .code_o     (code_a[ch]),
            .over_o     (over_a[ch])
        );
    end

    assign code_l_o = code_a[0];
    assign code_r_o = code_a[1];
    assign ovfl_o   = word_lr_i ? over_a[1] : over_a[0];

    p_mode_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(bar_mode_q));

    p_ovfl_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_lr_i && !bar_mode_q) |-> ovfl_o == code_l_o[7]);

    p_ovfl_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_lr_i && !bar_mode_q) |-> ovfl_o == code_r_o[7]);

    p_ovfl_bar_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_mode_q && ovfl_o) |-> (word_lr_i ? code_r_o : code_l_o) == 8'hFF);

endmodule

// File: tb/peak_level_meter_tb.sv
`timescale 1ns/1ps
module peak_level_meter_tb;

    localparam int FS = 524288;

    typedef struct {
        logic [7:0] cl;
        logic [7:0] cr;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] smp_l = '0;
    logic        smp_l_vld = 1'b0;
    logic [21:0] smp_r = '0;
    logic        smp_r_vld = 1'b0;
    logic        pk_upd_n = 1'b1;
    logic        bar_sel = 1'b0;
    logic        word_lr = 1'b0;
    logic [7:0]  code_l;
    logic [7:0]  code_r;
    logic        ovfl;

    int   n_total = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    bit   bar_m = 1'b0;
    int   act_l = 0;
    int   act_r = 0;
    exp_t sb_q[$];
    logic [7:0] last_l;
    logic [7:0] last_r;

    always #2 clk = ~clk;

    peak_level_meter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_l_i     (smp_l),
        .smp_l_vld_i (smp_l_vld),
        .smp_r_i     (smp_r),
        .smp_r_vld_i (smp_r_vld),
        .pk_upd_n_i  (pk_upd_n),
        .bar_sel_i   (bar_sel),
        .word_lr_i   (word_lr),
        .code_l_o    (code_l),
        .code_r_o    (code_r),
        .ovfl_o      (ovfl)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int mag_of(input int s);
        if (s == -2097152) return 2097151;
        return (s < 0) ? -s : s;
    endfunction

    // Expected code from the requirement tables, computed in dB
    function automatic logic [7:0] exp_code(input int mag, input bit bar);
        real db;
        int  a;
        if (mag > FS) begin
            if (bar) return 8'hFF;
            db = 20.0 * $log10(real'(mag) / real'(FS));
            a  = int'($floor(db));
            if (a > 3) a = 3;
            return 8'h80 | 8'(a);
        end
        if (mag == 0) return bar ? 8'h00 : 8'h7C;
        db = 20.0 * $log10(real'(mag) / real'(FS));
        if (bar) begin
            if (db >= -3.0)  return 8'h7F;
            if (db >= -6.0)  return 8'h3F;
            if (db >= -10.0) return 8'h1F;
            if (db >= -20.0) return 8'h0F;
            if (db >= -30.0) return 8'h07;
            if (db >= -40.0) return 8'h03;
            if (db >= -60.0) return 8'h01;
            return 8'h00;
        end
        a = int'($floor(-db));
        if (-db > 60.0) return 8'h7C;
        if (a > 60) a = 60;
        return 8'(a);
    endfunction

    task automatic do_reset(input bit bar);
        @(negedge clk);
        rst_n = 1'b0;
        bar_sel = bar;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bar_sel = ~bar;
        bar_m = bar;
        act_l = 0;
        act_r = 0;
        @(negedge clk);
    endtask

    // Drive one sample pair for one cycle; model the running peak
    task automatic put_smp(input int l, input bit lv, input int r, input bit rv);
        @(negedge clk);
        smp_l = 22'(l);
        smp_l_vld = lv;
        smp_r = 22'(r);
        smp_r_vld = rv;
        if (lv && mag_of(l) > act_l) act_l = mag_of(l);
        if (rv && mag_of(r) > act_r) act_r = mag_of(r);
        @(negedge clk);
        smp_l_vld = 1'b0;
        smp_r_vld = 1'b0;
    endtask

    // Falling edge on update; optional left sample in the cycle it takes effect
    task automatic do_update(input string tag, input bit cs, input int cl);
        exp_t e;
        bit   ovl;
        bit   ovr;
        @(negedge clk);
        pk_upd_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (cs) begin
            smp_l = 22'(cl);
            smp_l_vld = 1'b1;
        end
        @(negedge clk);
        smp_l_vld = 1'b0;
        e.cl  = exp_code(act_l, bar_m);
        e.cr  = exp_code(act_r, bar_m);
        e.tag = tag;
        ovl = act_l > FS;
        ovr = act_r > FS;
        last_l = e.cl;
        last_r = e.cr;
        sb_q.push_back(e);
        act_l = cs ? mag_of(cl) : 0;
        act_r = 0;
        #2;
        word_lr = 1'b0;
        #0.5;
        chk(ovfl == ovl, {tag, " R8 left phase ovfl"}, ovfl, ovl);
        word_lr = 1'b1;
        #0.5;
        chk(ovfl == ovr, {tag, " R8 right phase ovfl"}, ovfl, ovr);
        word_lr = 1'b0;
        pk_upd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pops expected codes and compares them with the outputs
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                chk(code_l == e.cl, {e.tag, " left code"}, code_l, e.cl);
                chk(code_r == e.cr, {e.tag, " right code"}, code_r, e.cr);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        // R11: reset state in fine mode
        #1;
        chk(code_l == 8'h7C, "R11 reset left code", code_l, 8'h7C);
        chk(code_r == 8'h7C, "R11 reset right code", code_r, 8'h7C);
        chk(ovfl == 1'b0, "R11 reset ovfl", ovfl, 0);

        // R1 R3: peak of several samples, below full scale
        put_smp(100000, 1, 600, 1);
        put_smp(-400000, 1, -200, 1);
        put_smp(50000, 1, 0, 0);
        put_smp(-800000, 0, 900000, 0);
        do_update("R1 R3 peak hold", 0, 0);

        // R1 R4: tracker was restarted, so silence is reported
        do_update("R1 R4 cleared tracker", 0, 0);

        // R9: samples alone do not move the held codes
        put_smp(600000, 1, 800000, 1);
        repeat (5) @(negedge clk);
        #1;
        chk(code_l == last_l, "R9 no edge left unchanged", code_l, last_l);
        chk(code_r == last_r, "R9 no edge right unchanged", code_r, last_r);

        // R5 R8: over-range up to +3 dB on both channels
        do_update("R5 over-range", 0, 0);

        // R2 R5: most negative input saturates; exactly full scale is not over
        put_smp(-2097152, 1, 524288, 1);
        do_update("R2 R5 saturate and full scale", 0, 0);
        put_smp(524289, 1, 300, 1);
        do_update("R5 R4 just over and idle", 0, 0);

        // R10: sample coinciding with the update goes to the new tracker
        put_smp(100000, 1, 30000, 1);
        do_update("R10 coincident excluded", 1, 800000);
        do_update("R10 coincident kept", 0, 0);

        // R7 R6 R11: bar mode captured in reset, select pin then flipped
        do_reset(1'b1);
        #1;
        chk(code_l == 8'h00, "R11 R7 bar reset left", code_l, 8'h00);
        chk(code_r == 8'h00, "R11 R7 bar reset right", code_r, 8'h00);
        put_smp(400000, 1, 100000, 1);
        do_update("R6 R7 bar top segments", 0, 0);
        put_smp(200000, 1, 300000, 1);
        do_update("R6 bar mid segments", 0, 0);
        put_smp(8000, 1, 30000, 1);
        do_update("R6 bar low segments", 0, 0);
        put_smp(600, 1, 4000, 1);
        do_update("R6 bar floor segments", 0, 0);
        put_smp(600000, 1, 300, 1);
        do_update("R6 R8 bar overflow and silence", 0, 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule